// File: doc/BRIEF.md
# Leading-One Scalar Bit Sequencer

This block feeds bit-serial arithmetic engines, such as double-and-add scalar multipliers or square-and-multiply exponentiators. These engines only need to see the bits of a scalar from its highest set bit downward. A host loads a 32-bit scalar. One cycle later a staged shift-and-count normalizer has removed the leading zeros and recorded how many there were. From then on the block presents one scalar bit per accepted step, starting at the leading one and ending at bit 0. With each bit it gives the bit's position and flags that mark the opening and closing iterations.

The number of iterations therefore equals the significant length of the scalar, not the word width. A one-hot end marker, loaded with a single 1 at the position of the leading one, shifts down with every step and signals the final iteration when it reaches position 0. A zero scalar has no significant bits. It goes straight to the finished state with length 0. A new load is accepted in any state and restarts the sequence. The reset input is asynchronous and active low, and its release is expected to be synchronous to the clock.

Top module: `msb_bit_iterator`

## Requirements
- R1: After reset, busy_o, done_o, bit_o, first_o, last_o are 0, and index_o and length_o are 0.
- R2: The cycle after load_i is sampled high, busy_o is 1 and done_o, first_o, bit_o are 0. This is the normalization cycle, and no bit is presented in it.
- R3: From the cycle after the normalization cycle until the next load, length_o equals 32 minus the number of leading zeros of the loaded scalar, or 0 for a zero scalar.
- R4: Across the iterations, bit_o presents scalar bits from position length-1 down to position 0, one per accepted step. Exactly length iterations occur, and the first presented bit is always 1.
- R5: index_o equals the position of the bit on bit_o and decreases by one after each accepted step.
- R6: first_o is 1 only on the iteration for position length-1. last_o is 1 only on the iteration for position 0. Both are 1 together for a scalar of 1.
- R7: While iterating, a cycle with step_i low changes none of bit_o, index_o, first_o, last_o.
- R8: A step accepted while last_o is 1 gives done_o=1 and busy_o=0 in the next cycle. done_o stays 1 until the next load.
- R9: A zero scalar gives done_o=1 and length_o=0 in the cycle after normalization, with no iteration presented.
- R10: A load while iterating abandons the current scalar and starts the new one with its own normalization cycle.
- R11: A scalar with bit 31 set gives 32 iterations. A scalar of 17 gives 5 iterations with bits 1,0,0,0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scalar_i | input | 32 | Scalar to iterate over, captured on load |
| load_i | input | 1 | Capture scalar_i and restart |
| step_i | input | 1 | Consume the presented bit and advance |
| bit_o | output | 1 | Current scalar bit (0 when not iterating) |
| first_o | output | 1 | Current bit is the leading one |
| last_o | output | 1 | Current bit is bit 0 |
| index_o | output | 5 | Position of the current bit |
| length_o | output | 6 | Significant bit length of the scalar |
| busy_o | output | 1 | Normalizing or iterating |
| done_o | output | 1 | All bits have been presented |

## Verification
The bench targets several corner cases. A zero scalar must finish with no iterations; a design that derives the length from the shift amount alone would report length 1 and emit a spurious bit. A scalar of 1 must raise first and last in the same cycle, and a scalar with bit 31 set must run all 32 positions; an off-by-one in the marker load would end one step early or late. Random stall gaps check that nothing advances without a step. A reload in the middle of a sequence must restart cleanly and not carry over the old marker or index.

// File: rtl/bititer_pkg.sv
package bititer_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } iter_state_e;
endpackage

// File: rtl/lz_normalizer.sv
// Staged shift-and-count: stage s tests the top 2**s bits and shifts them out.
module lz_normalizer #(
  parameter int W = 32
) (
  input  logic [W-1:0]         value_i,
  output logic [W-1:0]         norm_o,
  output logic [$clog2(W)-1:0] shift_o,
  output logic                 zero_o
);
  localparam int SW = $clog2(W);

  logic [SW:0][W-1:0] stage_v;
  logic [SW-1:0]      amt;

  assign stage_v[0] = value_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S  = SW - 1 - k;
    localparam int SH = 1 << S;
    logic hit;
    assign hit          = ~|stage_v[k][W-1 -: SH];
    assign stage_v[k+1] = hit ? (stage_v[k] << SH) : stage_v[k];
    assign amt[S]       = hit;
  end

  assign norm_o  = stage_v[SW];
  assign shift_o = amt;
  assign zero_o  = ~|value_i;
endmodule

// File: rtl/marker_reg.sv
// One-hot end marker: loaded at the leading-one position, shifted toward bit 0.
module marker_reg #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic                 clear_i,
  input  logic [$clog2(W)-1:0] pos_i,
  input  logic                 shift_en,
  output logic [W-1:0]         marker_o
);
  logic [W-1:0] marker_q;
  logic [W-1:0] marker_d;
  logic         marker_en;

  always_comb begin
    marker_d  = marker_q;
    marker_en = load_en | shift_en;
    if (load_en) begin
      marker_d = clear_i ? '0 : (W'(1) << pos_i);
    end else if (shift_en) begin
      marker_d = marker_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      marker_q <= '0;
    end else if (marker_en) begin
      marker_q <= marker_d;
    end
  end

  assign marker_o = marker_q;
endmodule

// File: rtl/iter_ctrl.sv
module iter_ctrl
  import bititer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic step_i,
  input  logic zero_i,
  input  logic last_i,
  output logic cap_en_o,
  output logic norm_en_o,
  output logic adv_en_o,
  output logic run_o,
  output logic busy_o,
  output logic done_o
);
  iter_state_e state_q;
  iter_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d = ST_NORM;
    end else begin
      unique case (state_q)
        ST_NORM: state_d = zero_i ? ST_DONE : ST_RUN;
        ST_RUN:  if (step_i && last_i) state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign cap_en_o  = load_i;
  assign norm_en_o = (state_q == ST_NORM) && !load_i;
  assign adv_en_o  = (state_q == ST_RUN) && step_i && !load_i;
  assign run_o     = (state_q == ST_RUN);
  assign busy_o    = (state_q == ST_NORM) || (state_q == ST_RUN);
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/iter_datapath.sv
module iter_datapath #(
  parameter int W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_en,
  input  logic                   norm_en,
  input  logic                   adv_en,
  input  logic [W-1:0]           scalar_i,
  input  logic [W-1:0]           norm_i,
  input  logic [$clog2(W)-1:0]   shift_i,
  input  logic                   zero_i,
  output logic [W-1:0]           raw_o,
  output logic                   msb_o,
  output logic                   first_o,
  output logic [$clog2(W)-1:0]   index_o,
  output logic [$clog2(W+1)-1:0] length_o
);
  localparam int SW = $clog2(W);
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  raw_q,   raw_d;
  logic [W-1:0]  work_q,  work_d;
  logic [SW-1:0] idx_q,   idx_d;
  logic [LW-1:0] len_q,   len_d;
  logic          first_q, first_d;
  logic          work_en;

  assign raw_d   = scalar_i;
  assign work_en = norm_en | adv_en;

  always_comb begin
    work_d  = work_q;
    idx_d   = idx_q;
    len_d   = len_q;
    first_d = first_q;
    if (norm_en) begin
      work_d  = norm_i;
      idx_d   = SW'(W - 1) - shift_i;
      len_d   = zero_i ? '0 : (LW'(W) - LW'(shift_i));
      first_d = !zero_i;
    end else if (adv_en) begin
      work_d  = work_q << 1;
      idx_d   = idx_q - 1'b1;
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (cap_en) begin
      raw_q <= raw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q  <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      first_q <= 1'b0;
    end else if (work_en) begin
      work_q  <= work_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      first_q <= first_d;
    end
  end

  assign raw_o    = raw_q;
  assign msb_o    = work_q[W-1];
  assign first_o  = first_q;
  assign index_o  = idx_q;
  assign length_o = len_q;
endmodule

// File: rtl/msb_bit_iterator.sv
module msb_bit_iterator #(
  parameter int W = bititer_pkg::WORD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [W-1:0]           scalar_i,
  input  logic                   load_i,
  input  logic                   step_i,
  output logic                   bit_o,
  output logic                   first_o,
  output logic                   last_o,
  output logic [$clog2(W)-1:0]   index_o,
  output logic [$clog2(W+1)-1:0] length_o,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int SW = $clog2(W);
  localparam int LW = $clog2(W + 1);

  logic          cap_en, norm_en, adv_en, run_w;
  logic [W-1:0]  raw_w, norm_w, marker_w;
  logic [SW-1:0] shift_w, idx_w;
  logic [LW-1:0] len_w;
  logic          zero_w, msb_w, first_w;

  iter_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .step_i    (step_i),
    .zero_i    (zero_w),
    .last_i    (marker_w[0]),
    .cap_en_o  (cap_en),
    .norm_en_o (norm_en),
    .adv_en_o  (adv_en),
    .run_o     (run_w),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  lz_normalizer #(.W(W)) u_norm (
    .value_i (raw_w),
    .norm_o  (norm_w),
    .shift_o (shift_w),
    .zero_o  (zero_w)
  );

  iter_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .norm_en  (norm_en),
    .adv_en   (adv_en),
    .scalar_i (scalar_i),
    .norm_i   (norm_w),
    .shift_i  (shift_w),
    .zero_i   (zero_w),
    .raw_o    (raw_w),
    .msb_o    (msb_w),
    .first_o  (first_w),
    .index_o  (idx_w),
    .length_o (len_w)
  );

  marker_reg #(.W(W)) u_marker (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (norm_en),
    .clear_i  (zero_w),
    .pos_i    (SW'(W - 1) - shift_w),
    .shift_en (adv_en),
    .marker_o (marker_w)
  );

  assign bit_o    = run_w & msb_w;
  assign first_o  = run_w & first_w;
  assign last_o   = run_w & marker_w[0];
  assign index_o  = idx_w;
  assign length_o = len_w;
endmodule

// File: rtl/msb_bit_iterator_chk.sv
module msb_bit_iterator_chk #(
  parameter int W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   load_i,
  input logic                   step_i,
  input logic                   bit_o,
  input logic                   first_o,
  input logic                   last_o,
  input logic [$clog2(W)-1:0]   index_o,
  input logic [$clog2(W+1)-1:0] length_o,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   run_i,
  input logic [W-1:0]           marker_i
);
  localparam int SW = $clog2(W);

  AST_NORM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (busy_o && !first_o && !done_o && !bit_o)); // R2

  AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    first_o |-> bit_o); // R4

  AST_FIRST_POS: assert property (@(posedge clk) disable iff (!rst_n)
    first_o |-> ({1'b0, index_o} == length_o - 1'b1)); // R6

  AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (index_o == '0)); // R6

  AST_MARKER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> ($countones(marker_i) == 1)); // R6

  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> ({1'b0, index_o} < length_o)); // R5

  AST_INDEX_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && step_i && !load_i && !last_o) |=> (index_o == SW'($past(index_o) - 1'b1))); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !step_i && !load_i) |=> ($stable(index_o) && $stable(bit_o) && $stable(first_o) && $stable(last_o))); // R7

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && step_i && !load_i) |=> (done_o && !busy_o)); // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> done_o); // R8

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R8
endmodule

bind msb_bit_iterator msb_bit_iterator_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_i   (load_i),
  .step_i   (step_i),
  .bit_o    (bit_o),
  .first_o  (first_o),
  .last_o   (last_o),
  .index_o  (index_o),
  .length_o (length_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .run_i    (run_w),
  .marker_i (marker_w)
);

// File: tb/msb_bit_iterator_tb_top.sv
module msb_bit_iterator_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] scalar_i;
  logic        load_i;
  logic        step_i;
  logic        bit_o, first_o, last_o, busy_o, done_o;
  logic [4:0]  index_o;
  logic [5:0]  length_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  msb_bit_iterator dut_i (
    .clk(clk), .rst_n(rst_n), .scalar_i(scalar_i), .load_i(load_i), .step_i(step_i),
    .bit_o(bit_o), .first_o(first_o), .last_o(last_o), .index_o(index_o),
    .length_o(length_o), .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int sig_len(input logic [31:0] v);
    for (int p = 31; p >= 0; p--) begin
      if (v[p]) return p + 1;
    end
    return 0;
  endfunction

  // Loads v, consumes up to cut iterations (cut<0: all), with random stalls.
  task automatic run_scalar(input logic [31:0] v, input int cut);
    int len;
    int n;
    len = sig_len(v);
    n = (cut < 0 || cut > len) ? len : cut;
    scalar_i = v; load_i = 1'b1; step_i = 1'b0;
    @(posedge clk); @(negedge clk);
    load_i = 1'b0; scalar_i = $urandom();
    chk("R2 busy in normalize", busy_o, 1);
    chk("R2 no first in normalize", {first_o, bit_o, done_o}, 0);
    @(posedge clk); @(negedge clk);
    chk("R3 length", length_o, len);
    if (len == 0) begin
      chk("R9 zero done", {done_o, busy_o, first_o, last_o, bit_o}, 5'b10000);
      return;
    end
    for (int i = 0; i < n; i++) begin
      int p;
      int stalls;
      p = len - 1 - i;
      chk("R4 bit value", bit_o, v[p]);
      chk("R5 index", index_o, p);
      chk("R6 first flag", first_o, (i == 0));
      chk("R6 last flag", last_o, (p == 0));
      stalls = $urandom_range(0, 2);
      for (int s = 0; s < stalls; s++) begin
        @(posedge clk); @(negedge clk);
        chk("R7 stall hold", {bit_o, first_o, last_o, index_o}, {v[p], i == 0, p == 0, 5'(p)});
      end
      step_i = 1'b1;
      @(posedge clk); @(negedge clk);
      step_i = 1'b0;
    end
    if (n == len) begin
      chk("R8 done after last", {done_o, busy_o, bit_o}, 3'b100);
      @(posedge clk); @(negedge clk);
      chk("R8 done held", done_o, 1);
      chk("R3 length held", length_o, len);
    end else begin
      chk("R10 still iterating before reload", busy_o, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; load_i = 1'b0; step_i = 1'b0; scalar_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset flags", {busy_o, done_o, bit_o, first_o, last_o}, 0);
    chk("R1 reset index/length", {index_o, length_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {busy_o, done_o}, 0);

    run_scalar(32'd17, -1);          // R11 five iterations 1,0,0,0,1
    run_scalar(32'd1, -1);           // R6 first and last together
    run_scalar(32'h8000_0001, -1);   // R11 full 32 iterations
    run_scalar(32'hFFFF_FFFF, -1);
    run_scalar(32'd0, -1);           // R9
    run_scalar(32'h0001_0000, -1);
    run_scalar(32'h00F0_0F00, 4);    // R10 abandoned mid-run
    run_scalar(32'd5, -1);           // R10 restart with new scalar
    run_scalar(32'hDEAD_BEEF, 10);   // R10
    run_scalar(32'd0, -1);           // R10 reload to zero
    for (int t = 0; t < 300; t++) begin
      logic [31:0] v;
      v = $urandom() >> $urandom_range(0, 31);
      if ($urandom_range(0, 9) == 0) run_scalar(v, $urandom_range(0, 6));
      else run_scalar(v, -1);
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule